// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts where a return instruction will go. A front end reports call events, each with the address the matching return should come back to. It also reports return events. The block keeps the most recent return addresses in a small last-in-first-out stack. A return takes its prediction from the top of that stack and removes the entry.

When the stack is empty, the block does not invent a target. It passes through a last-seen target that the branch buffer supplies for the same instruction, which is the fallback used for indirect jumps. A flag shows which of the two sources produced the target.

The stack has four entries by default. With nesting deeper than that, the innermost four returns are served from the stack. The outer returns use the fallback until new calls refill the stack.

The prediction is combinational. In any cycle, the target output and the source flag show what a return in that cycle receives. They are computed from the stack as it stands before that cycle's updates. All stack updates take effect at the next rising clock edge.

Top module: `ret_stack_pred`

## Requirements
- R1: After reset the stack is empty. The source flag `pred_from_stack` is 0 and `pred_target` equals `fallback_target`.
- R2: A call cycle with no return pushes `call_ret_addr`. In the next cycle `pred_from_stack` is 1 and `pred_target` is that address.
- R3: Returns are served in last-in-first-out order: each return removes the newest entry still held, and the next return predicts the entry below it.
- R4: Whenever the stack is empty, `pred_from_stack` is 0 and `pred_target` follows `fallback_target` combinationally, in the same cycle.
- R5: The stack holds DEPTH (4) entries. After more than DEPTH consecutive calls, exactly DEPTH returns are served from the stack, newest first. Every further return uses the fallback.
- R6: A call on a full stack discards the oldest entry and keeps the newest DEPTH. The occupancy never exceeds DEPTH.
- R7: A return on an empty stack leaves the stack empty and unchanged. A following call and two returns predict first that call's address and then the fallback.
- R8: A cycle with both a call and a return on a non-empty stack predicts the old top. It then replaces the top with the new return address and keeps the occupancy unchanged. The entries below the top are untouched.
- R9: A cycle with both a call and a return on an empty stack predicts the fallback. It leaves exactly one entry, the new return address.
- R10: For any mix of call-only, return-only, both and idle cycles, the outputs match a four-entry last-in-first-out model that drops the oldest entry on overflow and treats a simultaneous call and return as pop then push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| call_valid | input | 1 | A call is seen this cycle |
| call_ret_addr | input | ADDR_W | Return address of that call |
| ret_valid | input | 1 | A return is seen this cycle |
| fallback_target | input | ADDR_W | Last target from the branch buffer, used when the stack is empty |
| pred_target | output | ADDR_W | Predicted return target |
| pred_from_stack | output | 1 | 1 when the target comes from the stack, 0 when it is the fallback |

## Verification
The bench goes after the edges of the occupancy count.

- Six calls in a row test overflow. A design that dropped the newest entry instead of the oldest would serve the wrong addresses. A count that did not saturate at four would claim stack hits for the fifth and sixth returns.
- Returns on an empty stack test the lower edge. A count that wrapped below zero would later report stale entries as stack predictions.
- Simultaneous call and return cycles, on both full and empty stacks, test the pop-then-push order. A design that pushed first would predict the new address. A design that ignored the pop would grow the stack.
- A long pseudo-random sweep compares every cycle against an arithmetic model of the stack.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    // Stack operation chosen for one cycle
    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,   // nothing changes
        STK_PUSH = 2'd1,   // call only (or call with return on empty stack)
        STK_POP  = 2'd2,   // return on non-empty stack
        STK_SWAP = 2'd3    // call and return on non-empty stack: replace top
    } stk_op_e;

endpackage

// File: rtl/rsp_op_decode.sv
module rsp_op_decode
    import rsp_pkg::*;
(
    input  logic    call_valid,
    input  logic    ret_valid,
    input  logic    stack_nonempty,
    output stk_op_e op
);

    logic pop_eff;

    // A return only pops when there is something to pop
    assign pop_eff = ret_valid && stack_nonempty;

    always_comb begin
        unique case ({call_valid, pop_eff})
            2'b10:   op = STK_PUSH;
            2'b01:   op = STK_POP;
            2'b11:   op = STK_SWAP;
            default: op = STK_HOLD;
        endcase
    end

endmodule

// File: rtl/rsp_ctrl.sv
module rsp_ctrl
    import rsp_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stk_op_e          op,
    output logic [PTR_W-1:0] top_idx,
    output logic [CNT_W-1:0] occ,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [CNT_W-1:0] cnt;
    } ctl_s;

    ctl_s st_d, st_q;
    logic [PTR_W-1:0] ptr_inc, ptr_dec;

    always_comb begin
        ptr_inc = (st_q.ptr == LAST_IDX) ? '0 : st_q.ptr + 1'b1;
        ptr_dec = (st_q.ptr == '0) ? LAST_IDX : st_q.ptr - 1'b1;

        st_d   = st_q;
        wr_en  = 1'b0;
        wr_idx = st_q.ptr;

        unique case (op)
            STK_PUSH: begin
                // Circular storage: on a full stack the new top lands on the oldest slot
                st_d.ptr = ptr_inc;
                wr_en    = 1'b1;
                wr_idx   = ptr_inc;
                if (st_q.cnt != FULL_CNT) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            STK_POP: begin
                st_d.ptr = ptr_dec;
                st_d.cnt = st_q.cnt - 1'b1;
            end
            STK_SWAP: begin
                // Pop then push lands on the same slot; depth unchanged
                wr_en  = 1'b1;
                wr_idx = st_q.ptr;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign top_idx = st_q.ptr;
    assign occ     = st_q.cnt;

endmodule

// File: rtl/rsp_store.sv
module rsp_store #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_data
);

    logic [ADDR_W-1:0] ent_d [DEPTH];
    logic [ADDR_W-1:0] ent_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_comb begin
            ent_d[g] = ent_q[g];
            if (wr_en && (wr_idx == PTR_W'(g))) begin
                ent_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[g] <= '0;
            end else begin
                ent_q[g] <= ent_d[g];
            end
        end
    end

    assign rd_data = ent_q[rd_idx];

endmodule

// File: rtl/ret_stack_pred.sv
module ret_stack_pred
    import rsp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_valid,
    input  logic [ADDR_W-1:0] call_ret_addr,
    input  logic              ret_valid,
    input  logic [ADDR_W-1:0] fallback_target,
    output logic [ADDR_W-1:0] pred_target,
    output logic              pred_from_stack
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    stk_op_e           op;
    logic [PTR_W-1:0]  top_idx;
    logic [PTR_W-1:0]  wr_idx;
    logic [CNT_W-1:0]  occ_cnt;
    logic              wr_en;
    logic              stack_nonempty;
    logic [ADDR_W-1:0] top_addr;

    assign stack_nonempty = (occ_cnt != '0);

    rsp_op_decode u_dec (
        .call_valid     (call_valid),
        .ret_valid      (ret_valid),
        .stack_nonempty (stack_nonempty),
        .op             (op)
    );

    rsp_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .top_idx (top_idx),
        .occ     (occ_cnt),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx)
    );

    rsp_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (call_ret_addr),
        .rd_idx  (top_idx),
        .rd_data (top_addr)
    );

    // Prediction reflects state before this cycle's pop/push
    always_comb begin
        pred_from_stack = stack_nonempty;
        pred_target     = stack_nonempty ? top_addr : fallback_target;
    end

endmodule

// File: rtl/ret_stack_pred_chk.sv
module ret_stack_pred_chk #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              call_valid,
    input logic [ADDR_W-1:0] call_ret_addr,
    input logic              ret_valid,
    input logic [ADDR_W-1:0] fallback_target,
    input logic [ADDR_W-1:0] pred_target,
    input logic              pred_from_stack,
    input logic [CNT_W-1:0]  occ_cnt
);

    // R2
    push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_valid && !ret_valid) |=> (pred_from_stack && pred_target == $past(call_ret_addr)));

    // R4
    fallback_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_from_stack |-> (pred_target == fallback_target));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ_cnt <= CNT_W'(DEPTH));

    // R6
    full_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_valid && occ_cnt == CNT_W'(DEPTH)) |=> (occ_cnt == CNT_W'(DEPTH)));

    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !call_valid && occ_cnt == '0) |=> (occ_cnt == '0 && !pred_from_stack));

    // R5
    last_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !call_valid && occ_cnt == CNT_W'(1)) |=> !pred_from_stack);

    // R8
    swap_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_valid && ret_valid && occ_cnt != '0) |=>
            (occ_cnt == $past(occ_cnt) && pred_target == $past(call_ret_addr)));

    // R9
    swap_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_valid && ret_valid && occ_cnt == '0) |=> (occ_cnt == CNT_W'(1)));

endmodule

bind ret_stack_pred ret_stack_pred_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .call_valid      (call_valid),
    .call_ret_addr   (call_ret_addr),
    .ret_valid       (ret_valid),
    .fallback_target (fallback_target),
    .pred_target     (pred_target),
    .pred_from_stack (pred_from_stack),
    .occ_cnt         (occ_cnt)
);

// File: tb/ret_stack_pred_tb.sv
module ret_stack_pred_tb;

    localparam int  AW      = 32;
    localparam int  DEP     = 4;
    localparam time CLK_PER = 20ns;   // 50 MHz

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          call_valid = 1'b0;
    logic [AW-1:0] call_ret_addr = '0;
    logic          ret_valid = 1'b0;
    logic [AW-1:0] fallback_target = '0;
    logic [AW-1:0] pred_target;
    logic          pred_from_stack;

    int n_chk  = 0;
    int n_fail = 0;

    // Reference model: mdl[0] is the top
    logic [AW-1:0] mdl [DEP];
    int            mcnt = 0;

    always #(CLK_PER/2) clk = ~clk;

    ret_stack_pred #(.ADDR_W(AW), .DEPTH(DEP)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .call_valid      (call_valid),
        .call_ret_addr   (call_ret_addr),
        .ret_valid       (ret_valid),
        .fallback_target (fallback_target),
        .pred_target     (pred_target),
        .pred_from_stack (pred_from_stack)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic check(input string tag, input logic [AW-1:0] got_t, input logic got_f,
                         input logic [AW-1:0] exp_t, input logic exp_f);
        n_chk++;
        if (got_t !== exp_t || got_f !== exp_f) begin
            n_fail++;
            $display("FAIL %s: target=%h src=%b expected target=%h src=%b",
                     tag, got_t, got_f, exp_t, exp_f);
        end
    endtask

    // Drive one cycle, check the combinational prediction, update the model
    task automatic step(input logic c, input logic [AW-1:0] a, input logic r,
                        input logic [AW-1:0] fb, input string tag);
        logic [AW-1:0] exp_t;
        logic          exp_f;
        @(negedge clk);
        call_valid      = c;
        call_ret_addr   = a;
        ret_valid       = r;
        fallback_target = fb;
        #2;
        exp_f = (mcnt > 0);
        exp_t = exp_f ? mdl[0] : fb;
        check(tag, pred_target, pred_from_stack, exp_t, exp_f);
        if (r && mcnt > 0) begin
            for (int i = 0; i < DEP - 1; i++) mdl[i] = mdl[i+1];
            mcnt--;
        end
        if (c) begin
            for (int i = DEP - 1; i > 0; i--) mdl[i] = mdl[i-1];
            mdl[0] = a;
            if (mcnt < DEP) mcnt++;
        end
    endtask

    initial begin
        #(CLK_PER * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < DEP; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        step(1'b0, '0, 1'b0, 32'hAAAA_0001, "R1");
        step(1'b0, '0, 1'b1, 32'hAAAA_0002, "R1");

        // R2: single call then return
        step(1'b1, 32'h0000_1000, 1'b0, 32'h0, "R2");
        step(1'b0, '0, 1'b1, 32'hF000_0000, "R2");
        step(1'b0, '0, 1'b0, 32'hF000_0001, "R2");

        // R3: nested order
        step(1'b1, 32'h0000_2000, 1'b0, 32'h0, "R3");
        step(1'b1, 32'h0000_3000, 1'b0, 32'h0, "R3");
        step(1'b1, 32'h0000_4000, 1'b0, 32'h0, "R3");
        for (int k = 0; k < 4; k++) step(1'b0, '0, 1'b1, 32'hB000_0000 + k, "R3");

        // R4: empty stack follows fallback in the same cycle
        for (int k = 0; k < 4; k++) step(1'b0, '0, k[0], 32'h1234_0000 ^ (k << 8), "R4");

        // R5 and R6: six calls overflow a four-deep stack
        for (int k = 1; k <= 6; k++) step(1'b1, 32'h0005_0000 + k, 1'b0, 32'h0, "R6");
        for (int k = 0; k < 6; k++) step(1'b0, '0, 1'b1, 32'hC000_0000 + k, "R5");

        // R7: returns on empty, then one call
        step(1'b0, '0, 1'b1, 32'hD000_0001, "R7");
        step(1'b0, '0, 1'b1, 32'hD000_0002, "R7");
        step(1'b1, 32'h0007_0000, 1'b0, 32'h0, "R7");
        step(1'b0, '0, 1'b1, 32'hD000_0003, "R7");
        step(1'b0, '0, 1'b1, 32'hD000_0004, "R7");

        // R8: simultaneous call and return on non-empty stack
        step(1'b1, 32'h0008_0001, 1'b0, 32'h0, "R8");
        step(1'b1, 32'h0008_0002, 1'b0, 32'h0, "R8");
        step(1'b1, 32'h0008_0003, 1'b1, 32'hE000_0000, "R8");
        step(1'b0, '0, 1'b1, 32'hE000_0001, "R8");
        step(1'b0, '0, 1'b1, 32'hE000_0002, "R8");
        step(1'b0, '0, 1'b1, 32'hE000_0003, "R8");

        // R8 on a full stack
        for (int k = 1; k <= 4; k++) step(1'b1, 32'h0088_0000 + k, 1'b0, 32'h0, "R8");
        step(1'b1, 32'h0088_00FF, 1'b1, 32'hE100_0000, "R8");
        for (int k = 0; k < 5; k++) step(1'b0, '0, 1'b1, 32'hE100_0010 + k, "R8");

        // R9: simultaneous call and return on empty stack
        step(1'b1, 32'h0009_0000, 1'b1, 32'h9999_0000, "R9");
        step(1'b0, '0, 1'b1, 32'h9999_0001, "R9");
        step(1'b0, '0, 1'b1, 32'h9999_0002, "R9");

        // R10: pseudo-random sweep against the model
        lfsr = 16'hACE1;
        for (int k = 0; k < 4000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], {lfsr, 16'(k)}, lfsr[1], {16'(k), ~lfsr}, "R10");
        end

        @(negedge clk);
        call_valid = 1'b0;
        ret_valid  = 1'b0;
        finish_run();
    end

endmodule